// File: doc/BRIEF.md
# Loss-of-Signal Monitor

This block watches the recovered receive bit stream of a line receiver, one bit per enabled clock cycle, and decides whether the line has gone dead. A long unbroken run of spaces raises the loss flag. Once it is raised, the flag is lowered only after the ones density returns to at least one mark in eight, judged over a sliding window of the most recent bits. Entry and exit therefore use different tests, which gives the flag hysteresis.

The flag also serves as the select for an external glitch-free clock switch. While the flag is set, that switch replaces the recovered clock with the reference clock. A one-cycle change pulse accompanies every transition of the flag, for interrupt logic downstream. Received marks are forwarded in every state, so data still flows while the flag is set.

Top module: `los_monitor`

## Requirements
- R1: After a synchronous active-low reset, `los`, `clk_sel_ref` and `los_change` are 0, the space-run count is zero and the window holds no marks.
- R2: `los` goes to 1 at the clock edge that samples, with `bit_en` high, the LOS_RUN-th consecutive space (default 175; intended range 160 to 190). After LOS_RUN-1 spaces it is still 0.
- R3: A mark sampled with `bit_en` high restarts the space run, so a further LOS_RUN consecutive spaces are needed before `los` rises.
- R4: Cycles with `bit_en` low change nothing: the run count, the window and `los` keep their values, and `los_change` stays 0.
- R5: While `los` is 1, it returns to 0 at the edge that samples a bit that makes the last WIN_BITS sampled bits (32 by default, including that bit) hold at least MIN_MARKS marks (4 by default).
- R6: Marks spaced so that no 32-bit window holds 4 of them (for example, one every 11 bits) never clear `los`.
- R7: `mark_out` equals `rx_mark` AND `bit_en` in every state, including while `los` is 1.
- R8: `clk_sel_ref` is 1 exactly while `los` is 1 (1 selects the reference clock).
- R9: `los_change` is 1 for exactly the one cycle after each edge at which `los` changed, and 0 otherwise.
- R10: The space-run count saturates at LOS_RUN. An outage of any length keeps `los` at 1 with no further change pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks the cycles that carry a received bit |
| rx_mark | input | 1 | 1 = the received bit is a mark, 0 = a space |
| mark_out | output | 1 | Forwarded mark (rx_mark AND bit_en) |
| los | output | 1 | Loss-of-signal flag |
| clk_sel_ref | output | 1 | Clock switch select, 1 = reference clock |
| los_change | output | 1 | One-cycle pulse after each los transition |

## Verification
The run detector is tried with runs of exactly LOS_RUN-1 and LOS_RUN spaces, which separates an off-by-one entry from a correct one. A run broken by a single mark shows whether the count truly restarts. Marks one every 11 bits sit just below the density threshold, while a burst of marks seven bits apart crosses it; together they tell a sliding window apart from a cumulative count. Outages several times longer than the threshold check saturation. Gated cycles that carry marks show that idle cycles are ignored. Randomly gated segments of dense, sparse and silent traffic are compared bit by bit against a reference model in the bench.

// File: rtl/los_pkg.sv
// Shared types for the loss-of-signal monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package los_pkg;

    // Line state as seen by the monitor.
    typedef enum logic {
        LINE_OK   = 1'b0,
        LINE_LOST = 1'b1
    } line_state_e;

endpackage

// File: rtl/los_zero_run.sv
// Counts consecutive received spaces and flags the bit that completes a
// run of RUN_LEN spaces. The count saturates at RUN_LEN.
// Assumes: one bit per cycle with bit_en high; RUN_LEN >= 2.
module los_zero_run #(
    parameter int RUN_LEN = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    output logic run_hit
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(RUN_LEN);
    localparam logic [CW-1:0] CNT_LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_cnt;

    // Space-run counter: a mark clears it, a space advances it up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (bit_en) begin
            if (mark)
                run_cnt <= '0;
            else if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // The current space brings the run to RUN_LEN or keeps it saturated.
    always_comb begin
        run_hit = bit_en && !mark && (run_cnt >= CNT_LAST);
    end

    // R10
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_MAX);

    // R3
    mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mark) |=> (run_cnt == '0));

endmodule

// File: rtl/los_density_win.sv
// Keeps the last WIN bits in a shift register with a running mark count,
// updated by one add and one subtract per bit. Flags the bit after which
// the window holds at least MIN_MARKS marks.
// Assumes: MIN_MARKS <= WIN.
module los_density_win #(
    parameter int WIN       = 32,
    parameter int MIN_MARKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    output logic dense_hit
);
    localparam int PW = $clog2(WIN + 1);
    localparam logic [PW-1:0] NEED = PW'(MIN_MARKS);

    logic [WIN-1:0] win_bits;
    logic [PW-1:0]  pop;
    logic [PW-1:0]  pop_nxt;

    // Next mark count: add the incoming bit, drop the bit that leaves.
    always_comb begin
        pop_nxt   = pop + PW'(mark) - PW'(win_bits[WIN-1]);
        dense_hit = bit_en && (pop_nxt >= NEED);
    end

    // Window shift register and running count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_bits <= '0;
            pop      <= '0;
        end else if (bit_en) begin
            win_bits <= {win_bits[WIN-2:0], mark};
            pop      <= pop_nxt;
        end
    end

    // R5
    pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop) == $countones(win_bits));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(win_bits));

endmodule

// File: rtl/los_state.sv
// Holds the loss flag: it enters on a completed space run and leaves on the
// density test. It also emits a one-cycle pulse after each transition.
// Assumes: run_hit and dense_hit are already qualified by bit_en.
module los_state (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic run_hit,
    input  logic dense_hit,
    output logic los,
    output logic los_change
);
    import los_pkg::*;

    line_state_e st, st_nxt;

    // Next-state choice: the entry and exit tests differ (hysteresis).
    always_comb begin
        st_nxt = st;
        unique case (st)
            LINE_OK:   if (run_hit)   st_nxt = LINE_LOST;
            LINE_LOST: if (dense_hit) st_nxt = LINE_OK;
            default:   st_nxt = LINE_OK;
        endcase
    end

    // State register and change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= LINE_OK;
            los_change <= 1'b0;
        end else begin
            st         <= st_nxt;
            los_change <= (st_nxt != st);
        end
    end

    assign los = (st == LINE_LOST);

    // R2
    enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(run_hit));

    // R5
    leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(dense_hit));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los != $past(los)) |-> los_change);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los_change |=> !los_change);

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!los_change && $stable(los)));

endmodule

// File: rtl/los_monitor.sv
// Loss-of-signal monitor top: space-run detector, sliding density window
// and loss flag, plus mark forwarding and the clock-switch select.
// Assumes: LOS_RUN in 160..190 for line use; WIN_BITS >= MIN_MARKS.
module los_monitor #(
    parameter int LOS_RUN   = 175,
    parameter int WIN_BITS  = 32,
    parameter int MIN_MARKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_mark,
    output logic mark_out,
    output logic los,
    output logic clk_sel_ref,
    output logic los_change
);
    logic run_hit;
    logic dense_hit;

    los_zero_run #(.RUN_LEN(LOS_RUN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mark    (rx_mark),
        .run_hit (run_hit)
    );

    los_density_win #(.WIN(WIN_BITS), .MIN_MARKS(MIN_MARKS)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .mark      (rx_mark),
        .dense_hit (dense_hit)
    );

    los_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .run_hit    (run_hit),
        .dense_hit  (dense_hit),
        .los        (los),
        .los_change (los_change)
    );

    // Marks are forwarded regardless of the loss flag; the flag drives the switch.
    assign mark_out    = rx_mark & bit_en;
    assign clk_sel_ref = los;

endmodule

// File: tb/los_monitor_test.sv
`timescale 1ns/1ps
module los_monitor_test;
    localparam int RUN = 175;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx_mark = 1'b0;
    logic mark_out, los, clk_sel_ref, los_change;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    string cur_req = "R2";

    // reference model state
    int       m_zc = 0;
    bit [31:0] m_win = '0;
    bit       m_los = 0;
    bit       m_chg = 0;

    always #5 clk = ~clk;

    los_monitor uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_mark(rx_mark),
        .mark_out(mark_out), .los(los), .clk_sel_ref(clk_sel_ref),
        .los_change(los_change)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic void model_step(input bit en, input bit m);
        bit prev;
        prev  = m_los;
        m_chg = 0;
        if (!en) return;
        m_zc  = m ? 0 : ((m_zc < RUN) ? m_zc + 1 : RUN);
        m_win = {m_win[30:0], m};
        if (!m_los && m_zc == RUN) m_los = 1;
        else if (m_los && $countones(m_win) >= 4) m_los = 0;
        m_chg = (prev != m_los);
    endfunction

    task automatic send_bit(input logic en, input logic m);
        @(negedge clk);
        bit_en = en; rx_mark = m;
        #1;
        chk("R7", mark_out, en & m);
        model_step(en, m);
        @(posedge clk); #1;
        chk(cur_req, los, m_los);
        chk("R8", clk_sel_ref, m_los);
        chk("R9", los_change, m_chg);
    endtask

    task automatic spaces(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; rx_mark = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_zc = 0; m_win = '0; m_los = 0; m_chg = 0;
        chk("R1", los, 1'b0);
        chk("R1", clk_sel_ref, 1'b0);
        chk("R1", los_change, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: one short of the run, then the completing space
        cur_req = "R2";
        spaces(RUN - 1);
        chk("R2", los, 1'b0);
        spaces(1);
        chk("R2", los, 1'b1);

        // R5: marks 7 bits apart; the fourth clears the flag
        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            send_bit(1'b1, 1'b1);
            spaces(6);
            chk("R5", los, 1'b1);
        end
        send_bit(1'b1, 1'b1);
        chk("R5", los, 1'b0);

        // R3: run broken by one mark restarts the count
        cur_req = "R3";
        spaces(RUN - 1);
        send_bit(1'b1, 1'b1);
        spaces(RUN - 1);
        chk("R3", los, 1'b0);
        spaces(1);
        chk("R3", los, 1'b1);

        // R6: one mark every 11 bits stays below density
        cur_req = "R6";
        for (int k = 0; k < 20; k++) begin
            send_bit(1'b1, 1'b1);
            spaces(10);
        end
        chk("R6", los, 1'b1);

        // R10: long outage, saturated count, no extra pulses
        cur_req = "R10";
        spaces(4 * RUN);
        chk("R10", los, 1'b1);

        // R4: gated marks must not count toward density
        cur_req = "R4";
        for (int k = 0; k < 8; k++) send_bit(1'b0, 1'b1);
        chk("R4", los, 1'b1);
        chk("R4", los_change, 1'b0);
        cur_req = "R5";
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b1);
        chk("R5", los, 1'b1);
        send_bit(1'b1, 1'b1);
        chk("R5", los, 1'b0);

        // random segments: dense, sparse, silent, with gated cycles
        cur_req = "R2";
        for (int s = 0; s < 12; s++) begin
            int mode;
            mode = $urandom % 3;
            for (int i = 0; i < 300; i++) begin
                logic en, m;
                en = ($urandom % 4) != 0;
                case (mode)
                    0: m = ($urandom % 2) == 0;
                    1: m = ($urandom % 40) == 0;
                    default: m = 1'b0;
                endcase
                send_bit(en, m);
            end
        end

        // R1: reset from the lost state
        spaces(RUN);
        do_reset();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule